// File: doc/BRIEF.md
# Display Backend Clock Control Unit

This block produces the clock enable and the reset for a display backend engine. All of its timing runs on one fast system clock. Three candidate source clocks reach it as per-cycle enable strobes. One 32-bit control word chooses one of the three sources and sets an integer division ratio. The same word gates the divided enable and drives an active-low reset toward the engine.

The selected source's strobes are counted. One output strobe is emitted each time the count wraps. The output rate is therefore the source rate divided by the programmed ratio plus one.

Software reads the word, changes one field and writes the whole word back. The read therefore returns exactly what is stored, and every unused bit reads as zero. To pick a ratio, software takes the ceiling of the source rate over the wanted rate and subtracts one. The delivered rate then never exceeds the request.

Top module: `bclk_ctrl`

## Requirements
- R1: After synchronous reset the control word reads 0x00000000, `eng_rst_n` is 0 and `div_stb` is 0.
- R2: Bit 31 is the gate. `div_stb` can pulse only while bit 31 is 1; with bit 31 at 0 no pulse appears.
- R3: Bit 30 drives `eng_rst_n` directly. The engine is held in reset (`eng_rst_n` = 0) whenever bit 30 is 0, starting the cycle after the write.
- R4: Bits 25:24 select the source: code 0 counts `src_stb[0]`, code 1 counts `src_stb[1]`, code 2 counts `src_stb[2]`. At most one source is counted at a time.
- R5: A write carrying code 3 in bits 25:24 keeps the previous selection, while bits 31, 30 and 3:0 of that same write still take effect.
- R6: Bits 3:0 hold M (0..15). Once running, consecutive `div_stb` pulses are (M+1) selected source strobes apart, giving division by 1 to 16.
- R7: A new M or source takes effect only at the next wrap of the counter. The division in progress completes with the old settings.
- R8: A read returns the stored fields at their bit positions with every other bit 0. A read-modify-write of one field therefore leaves the others unchanged.
- R9: Programming M = ceil(wanted period / source period) - 1 yields an output period no shorter than the wanted period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to store |
| rd_data | output | 32 | Stored control word, unused bits zero |
| src_stb | input | 3 | Per-cycle enable strobes of the three source clocks |
| div_stb | output | 1 | Gated, divided clock enable |
| eng_rst_n | output | 1 | Active-low reset to the display engine |

## Verification
Several properties are checked by assertions on every cycle:
- the stored select code stays legal, and a bad code leaves it unchanged;
- the gate suppresses every output pulse;
- the count never passes the active ratio;
- the active ratio and source change only at a wrap;
- unused bits read as zero;
- at most one source is counted.

Other behaviour is shown only by the bench's scenarios. These are the actual pulse spacing for every source and every ratio, the deferral of a ratio change to the end of the running division, the read-modify-write preservation of fields, and the ceiling rule for rate requests.

// File: rtl/bclk_pkg.sv
package bclk_pkg;
    localparam int DATA_W    = 32;
    localparam int NUM_SRC   = 3;
    localparam int SEL_W     = 2;
    localparam int RATIO_W   = 4;
    localparam int GATE_BIT  = 31;
    localparam int RUN_BIT   = 30;
    localparam int SEL_LSB   = 24;
    localparam int RATIO_LSB = 0;

    typedef logic [SEL_W-1:0]   sel_t;
    typedef logic [RATIO_W-1:0] ratio_t;
    typedef logic [DATA_W-1:0]  word_t;

    localparam sel_t SEL_MAX = sel_t'(NUM_SRC - 1);

    typedef struct packed {
        logic   gate;
        logic   run;
        sel_t   sel;
        ratio_t ratio;
    } ctrl_t;

    function automatic ctrl_t unpack_word(input word_t w);
        ctrl_t c;
        c.gate  = w[GATE_BIT];
        c.run   = w[RUN_BIT];
        c.sel   = w[SEL_LSB +: SEL_W];
        c.ratio = w[RATIO_LSB +: RATIO_W];
        return c;
    endfunction

    function automatic word_t pack_word(input ctrl_t c);
        word_t w;
        w = '0;
        w[GATE_BIT]                = c.gate;
        w[RUN_BIT]                 = c.run;
        w[SEL_LSB +: SEL_W]        = c.sel;
        w[RATIO_LSB +: RATIO_W]    = c.ratio;
        return w;
    endfunction

    function automatic word_t used_mask();
        ctrl_t ones;
        ones = '1;
        return pack_word(ones);
    endfunction
endpackage

// File: rtl/bclk_regfile.sv
module bclk_regfile
    import bclk_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  word_t wr_data,
    output ctrl_t ctrl_o,
    output word_t rd_data
);
    ctrl_t q;
    ctrl_t nxt;

    always_comb nxt = unpack_word(wr_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (wr_en) begin
            q.gate  <= nxt.gate;
            q.run   <= nxt.run;
            q.ratio <= nxt.ratio;
            if (nxt.sel <= SEL_MAX) begin
                q.sel <= nxt.sel;
            end
        end
    end

    assign ctrl_o  = q;
    assign rd_data = pack_word(q);

    AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (rst)
        q.sel <= SEL_MAX);                                               // R5
    AST_BAD_SEL_KEEP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_data[SEL_LSB +: SEL_W] > SEL_MAX)) |=> $stable(q.sel)); // R5
    AST_RATIO_LOAD: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (q.ratio == $past(wr_data[RATIO_LSB +: RATIO_W])));    // R6
endmodule

// File: rtl/bclk_srcsel.sv
module bclk_srcsel
    import bclk_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_stb,
    input  sel_t               sel,
    output logic               sel_stb
);
    logic [NUM_SRC-1:0] hit;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign hit[g] = src_stb[g] && (sel == sel_t'(g));
    end

    assign sel_stb = |hit;

    AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit));                                                  // R4
endmodule

// File: rtl/bclk_divider.sv
module bclk_divider
    import bclk_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sel_stb,
    input  logic   gate,
    input  ratio_t ratio_req,
    input  sel_t   sel_req,
    output sel_t   sel_act,
    output logic   div_stb
);
    ratio_t cnt;
    ratio_t m_act;
    logic   wrap;

    assign wrap = sel_stb && (cnt == m_act);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            m_act   <= '0;
            sel_act <= '0;
            div_stb <= 1'b0;
        end else begin
            div_stb <= wrap && gate;
            if (wrap) begin
                cnt     <= '0;
                m_act   <= ratio_req;
                sel_act <= sel_req;
            end else if (sel_stb) begin
                cnt <= cnt + ratio_t'(1);
            end
        end
    end

    AST_GATE_OFF: assert property (@(posedge clk) disable iff (rst)
        !gate |=> !div_stb);                                             // R2
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= m_act);                                                   // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !sel_stb |=> $stable(cnt));                                      // R6
    AST_MID_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> ($stable(m_act) && $stable(sel_act)));                 // R7
endmodule

// File: rtl/bclk_ctrl.sv
module bclk_ctrl
    import bclk_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [DATA_W-1:0]  rd_data,
    input  logic [NUM_SRC-1:0] src_stb,
    output logic               div_stb,
    output logic               eng_rst_n
);
    ctrl_t ctrl;
    sel_t  sel_act;
    logic  sel_stb;

    bclk_regfile u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctrl_o  (ctrl),
        .rd_data (rd_data)
    );

    bclk_srcsel u_sel (
        .clk     (clk),
        .rst     (rst),
        .src_stb (src_stb),
        .sel     (sel_act),
        .sel_stb (sel_stb)
    );

    bclk_divider u_div (
        .clk       (clk),
        .rst       (rst),
        .sel_stb   (sel_stb),
        .gate      (ctrl.gate),
        .ratio_req (ctrl.ratio),
        .sel_req   (ctrl.sel),
        .sel_act   (sel_act),
        .div_stb   (div_stb)
    );

    assign eng_rst_n = ctrl.run;

    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_data & ~used_mask()) == '0);                                 // R8
    AST_RUN_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (eng_rst_n == $past(wr_data[RUN_BIT])));              // R3
endmodule

// File: tb/bclk_ctrl_tb_top.sv
module bclk_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [2:0]  src_stb = '0;
    logic        div_stb;
    logic        eng_rst_n;

    int cyc = 0;
    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Source k strobes once every k+1 cycles
    always @(negedge clk) begin
        src_stb[0] <= 1'b1;
        src_stb[1] <= (cyc % 2) == 0;
        src_stb[2] <= (cyc % 3) == 0;
    end

    bclk_ctrl dut_i (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .src_stb   (src_stb),
        .div_stb   (div_stb),
        .eng_rst_n (eng_rst_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input bit g, input bit r, input int s, input int m);
        logic [31:0] w;
        w = '0;
        w[31] = g;
        w[30] = r;
        w[25:24] = 2'(s);
        w[3:0] = 4'(m);
        return w;
    endfunction

    task automatic wr(input logic [31:0] d);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_pulse(output int t);
        int n;
        n = 0;
        t = -1;
        while (n < 400) begin
            @(negedge clk);
            n++;
            if (div_stb) begin
                t = cyc;
                break;
            end
        end
        if (t < 0) chk(1'b0, "R6 pulse timeout", n, 0);
    endtask

    initial begin
        int t0, t1, t2, t3, cnt, per, mval;
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(rd_data == 32'h0, "R1 rd_data", rd_data, 0);
        chk(eng_rst_n == 1'b0, "R1 eng_rst_n", eng_rst_n, 0);
        chk(div_stb == 1'b0, "R1 div_stb", div_stb, 0);

        // R3 engine reset follows bit 30
        wr(mk(0, 1, 0, 0));
        chk(eng_rst_n == 1'b1, "R3 release", eng_rst_n, 1);
        wr(mk(0, 0, 0, 0));
        chk(eng_rst_n == 1'b0, "R3 assert", eng_rst_n, 0);

        // R2 gate off: no pulses
        wr(mk(0, 1, 0, 0));
        cnt = 0;
        repeat (50) begin
            @(negedge clk);
            if (div_stb) cnt++;
        end
        chk(cnt == 0, "R2 gated off", cnt, 0);

        // R4 R6 sweep every source and ratio
        for (int s = 0; s < 3; s++) begin
            for (int m = 0; m < 16; m++) begin
                wr(mk(1, 1, s, m));
                wait_pulse(t0);
                wait_pulse(t0);
                wait_pulse(t1);
                wait_pulse(t2);
                chk((t1 - t0) == (m + 1) * (s + 1), "R4/R6 period a", t1 - t0, (m + 1) * (s + 1));
                chk((t2 - t1) == (m + 1) * (s + 1), "R4/R6 period b", t2 - t1, (m + 1) * (s + 1));
            end
        end

        // R7 ratio change waits for the running division
        wr(mk(1, 1, 0, 15));
        wait_pulse(t0);
        wait_pulse(t0);
        wait_pulse(t0);
        wr(mk(1, 1, 0, 0));
        wait_pulse(t1);
        wait_pulse(t2);
        chk((t1 - t0) == 16, "R7 old ratio finishes", t1 - t0, 16);
        chk((t2 - t1) == 1, "R7 new ratio after wrap", t2 - t1, 1);

        // R5 illegal code keeps select, other fields update
        wr(mk(1, 1, 2, 5));
        wr(mk(0, 0, 3, 9));
        chk(rd_data == mk(0, 0, 2, 9), "R5 bad select", rd_data, mk(0, 0, 2, 9));
        chk(eng_rst_n == 1'b0, "R5 run field", eng_rst_n, 0);

        // R8 unused bits read zero, RMW keeps fields
        wr(32'hFFFF_FFFF);
        chk(rd_data == 32'hC200_000F, "R8 unused zero", rd_data, 32'hC200_000F);
        v = rd_data;
        v[25:24] = 2'd1;
        wr(v);
        chk(rd_data == 32'hC100_000F, "R8 rmw select", rd_data, 32'hC100_000F);

        // R9 ceiling rule on source 1 (period 2)
        for (int w = 5; w <= 11; w += 3) begin
            mval = (w + 1) / 2 - 1;
            wr(mk(1, 1, 1, mval));
            wait_pulse(t0);
            wait_pulse(t0);
            wait_pulse(t1);
            per = t1 - t0;
            chk(per >= w, "R9 rate not above request", per, w);
        end

        // R2 gate turned back off while running
        wr(mk(0, 1, 0, 0));
        cnt = 0;
        repeat (20) begin
            @(negedge clk);
            if (div_stb) cnt++;
        end
        chk(cnt == 0, "R2 gate off again", cnt, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule